// File: doc/BRIEF.md
# Interrupt Request and Acknowledge Controller

This block decides, at each instruction boundary, whether the processor takes an interrupt. Two sources exist. One is a non-maskable input that reacts to a rising edge. The other is a maskable request that is sensitive to its level. A non-maskable edge is captured in a pending latch through a synchronizer, so the input does not have to be aligned to the clock. A pending non-maskable event always wins over the maskable request. It produces the fixed table address of type 2 without using the bus.

A maskable request is taken only when the enable flag is set. It then runs two acknowledge bus cycles, one straight after the other, through a bus cycle engine outside the block. During that pair the block drives the lock indication and holds off bus-hold grants. The byte read at the end of the second cycle is shifted left by two and becomes the address into the 1 KiB vector table. Each response also asks the core to clear its enable flag. While the core is halted, a qualifying interrupt is taken without waiting for a boundary, and the block flags a wake-up.

Top module: `irq_ack_ctrl`

## Requirements
- R1: After reset the block drives the following values.
  - `ackReq`, `lockOut`, `holdBlock`, `vecValid`, `clearIf` and `wakeOut` are low.
  - `bheN` is high.
- R2: If a non-maskable event is pending when the block is idle and sees `boundary` high, it takes that event even when the maskable request is also qualified. This response starts no acknowledge cycle (`ackReq` stays low). `vecValid` is high in the next cycle with `vecAddr` equal to 0x008.
- R3: A maskable request is taken at a boundary only if both of these hold:
  - `intrIn` was high at the previous rising clock edge;
  - `ifFlag` is high.
  A request that rises in the boundary cycle itself is not taken, and neither is one that arrives while `ifFlag` is low.
- R4: Taking a maskable request holds `ackReq` high for two bus cycles, each ended by a `busDone` pulse. `ackFirst` is 1 during the first cycle and 0 during the second.
- R5: `lockOut` is high only in two places:
  - phases T2, T3 and T4 of the first acknowledge cycle;
  - phase T1 of the second acknowledge cycle.
  The phase encoding on `busPhase` is T1=0, T2=1, T3=2, T4=3.
- R6: `holdBlock` is high from the cycle after a maskable request is taken up to and including the cycle in which the second `busDone` arrives.
- R7: The byte on `dataIn` with the second `busDone` is the type. `vecValid` is high in the next cycle, with `vecAddr` equal to the type times four.
- R8: `bheN` is low only in phase T1 of the first acknowledge cycle.
- R9: `clearIf` is high for exactly the cycle in which any response is taken.
- R10: Pending and repeat behaviour of the non-maskable input:
  - One rising edge stays pending until it is taken.
  - Holding the input high yields only one response.
  - A new rising edge that arrives while an earlier response is in progress yields a second response.
- R11: A non-maskable input that is high during reset, and stays high through the first two cycles after reset, produces no response.
- R12: While `haltIn` is high, a qualified interrupt is taken without a boundary pulse, and `wakeOut` pulses together with `clearIf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nmiIn | input | 1 | Non-maskable interrupt, rising-edge sensitive, asynchronous |
| intrIn | input | 1 | Maskable interrupt request, level sensitive |
| boundary | input | 1 | Pulse marking an instruction boundary |
| ifFlag | input | 1 | Interrupt enable flag from the core |
| haltIn | input | 1 | Core is in the halt state |
| busPhase | input | 2 | Phase of the running bus cycle (T1=0 .. T4=3) |
| busDone | input | 1 | Pulse in the last phase of a bus cycle |
| dataIn | input | 8 | Low data byte, holds the type with the second `busDone` |
| ackReq | output | 1 | Requests acknowledge bus cycles |
| ackFirst | output | 1 | 1 for the first acknowledge cycle, 0 for the second |
| lockOut | output | 1 | Bus lock indication, active high |
| bheN | output | 1 | Byte-high enable, active low |
| holdBlock | output | 1 | Blocks bus-hold grants |
| clearIf | output | 1 | Asks the core to clear its enable flag |
| wakeOut | output | 1 | Response taken while halted |
| vecValid | output | 1 | `vecAddr` is valid |
| vecAddr | output | 10 | Vector table byte address |

## Verification
The hardest case to reach is a second non-maskable edge that lands while an earlier response is still being serviced. It must be latched and then answered on its own later, while a level held high must never count twice. The stimulus starts a maskable acknowledge pair and pulses the non-maskable input in the middle of it. After the pair completes, one further boundary must produce the type 2 address. A separate run holds the non-maskable input high across a completed service and checks that the next boundary brings no response.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACK1,
    ST_ACK2,
    ST_VEC
  } irqState_t;

  typedef struct packed {
    logic loadNmiType;
    logic loadBusType;
    logic clrPend;
  } dpStrobe_t;

  localparam logic [1:0] PH_T1 = 2'd0;
endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NMI_GUARD   = 2,
  parameter int TYPE_W      = 8,
  parameter int NMI_TYPE    = 2,
  localparam int VEC_W      = TYPE_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nmiIn,
  input  logic              intrIn,
  input  logic [TYPE_W-1:0] dataIn,
  input  dpStrobe_t         strb,
  output logic              nmiPend,
  output logic              intrQ,
  output logic [VEC_W-1:0]  vecAddr
);
  localparam int GUARD_LEN = NMI_GUARD + SYNC_STAGES;
  localparam int GW        = $clog2(GUARD_LEN + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   nmiPrev;
  logic [GW-1:0]          guardCnt;
  logic                   armed;
  logic                   nmiEdge;
  logic [TYPE_W-1:0]      typeReg;

  // Reset to ones: a line that is already high at reset shows no edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ   <= '1;
      nmiPrev <= 1'b1;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], nmiIn};
      nmiPrev <= syncQ[SYNC_STAGES-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      guardCnt <= '0;
    else if (!armed)
      guardCnt <= guardCnt + 1'b1;
  end

  assign armed   = (guardCnt == GW'(GUARD_LEN));
  assign nmiEdge = armed && syncQ[SYNC_STAGES-1] && !nmiPrev;

  // A new edge wins over the clear taken in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)
      nmiPend <= 1'b0;
    else if (nmiEdge)
      nmiPend <= 1'b1;
    else if (strb.clrPend)
      nmiPend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      intrQ   <= 1'b0;
      typeReg <= '0;
    end else begin
      intrQ <= intrIn;
      if (strb.loadNmiType)
        typeReg <= TYPE_W'(NMI_TYPE);
      else if (strb.loadBusType)
        typeReg <= dataIn;
    end
  end

  assign vecAddr = {typeReg, 2'b00};

  AST_PEND_DROPS: assert property (@(posedge clk) disable iff (rst)
    (strb.clrPend && !nmiEdge) |=> !nmiPend); // R10
  AST_NMI_VECTOR: assert property (@(posedge clk) disable iff (rst)
    strb.loadNmiType |=> (vecAddr == VEC_W'(NMI_TYPE * 4))); // R2
  AST_GUARD_MASK: assert property (@(posedge clk) disable iff (rst)
    (!armed && !nmiPend) |=> !nmiPend); // R11
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       boundary,
  input  logic       haltIn,
  input  logic       ifFlag,
  input  logic       nmiPend,
  input  logic       intrQ,
  input  logic [1:0] busPhase,
  input  logic       busDone,
  output dpStrobe_t  strb,
  output logic       ackReq,
  output logic       ackFirst,
  output logic       lockOut,
  output logic       bheN,
  output logic       holdBlock,
  output logic       clearIf,
  output logic       wakeOut,
  output logic       vecValid
);
  irqState_t st, stNext;
  logic ready, takeNmi, takeIntr;

  assign ready    = (st == ST_IDLE) && (boundary || haltIn);
  assign takeNmi  = ready && nmiPend;
  assign takeIntr = ready && !nmiPend && intrQ && ifFlag;

  always_comb begin
    stNext = st;
    case (st)
      ST_IDLE: if (takeNmi) stNext = ST_VEC;
               else if (takeIntr) stNext = ST_ACK1;
      ST_ACK1: if (busDone) stNext = ST_ACK2;
      ST_ACK2: if (busDone) stNext = ST_VEC;
      ST_VEC:  stNext = ST_IDLE;
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= stNext;
  end

  always_comb begin
    strb.loadNmiType = takeNmi;
    strb.clrPend     = takeNmi;
    strb.loadBusType = (st == ST_ACK2) && busDone;
  end

  assign ackReq    = (st == ST_ACK1) || (st == ST_ACK2);
  assign ackFirst  = (st == ST_ACK1);
  assign holdBlock = ackReq;
  assign lockOut   = ((st == ST_ACK1) && (busPhase != PH_T1)) ||
                     ((st == ST_ACK2) && (busPhase == PH_T1));
  assign bheN      = !((st == ST_ACK1) && (busPhase == PH_T1));
  assign clearIf   = takeNmi || takeIntr;
  assign wakeOut   = clearIf && haltIn;
  assign vecValid  = (st == ST_VEC);

  AST_MASKED_STAYS: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !haltIn && !nmiPend && !ifFlag) |=> (st == ST_IDLE)); // R3
  AST_HOLD_UNTIL_SECOND: assert property (@(posedge clk) disable iff (rst)
    (holdBlock && !(st == ST_ACK2 && busDone)) |=> holdBlock); // R6
  AST_TAKE_PROGRESS: assert property (@(posedge clk) disable iff (rst)
    clearIf |=> (holdBlock || vecValid)); // R9
  AST_VEC_AFTER_SECOND: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ACK2 && busDone) |=> vecValid); // R7
  AST_LOCK_IN_ACK: assert property (@(posedge clk) disable iff (rst)
    lockOut |-> holdBlock); // R5
  AST_WAKE_WITH_TAKE: assert property (@(posedge clk) disable iff (rst)
    wakeOut |-> clearIf); // R12
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       nmiIn,
  input  logic       intrIn,
  input  logic       boundary,
  input  logic       ifFlag,
  input  logic       haltIn,
  input  logic [1:0] busPhase,
  input  logic       busDone,
  input  logic [7:0] dataIn,
  output logic       ackReq,
  output logic       ackFirst,
  output logic       lockOut,
  output logic       bheN,
  output logic       holdBlock,
  output logic       clearIf,
  output logic       wakeOut,
  output logic       vecValid,
  output logic [9:0] vecAddr
);
  dpStrobe_t strb;
  logic nmiPend, intrQ;

  irq_datapath #(
    .SYNC_STAGES(2), .NMI_GUARD(2), .TYPE_W(8), .NMI_TYPE(2)
  ) dp_i (
    .clk(clk), .rst(rst), .nmiIn(nmiIn), .intrIn(intrIn), .dataIn(dataIn),
    .strb(strb), .nmiPend(nmiPend), .intrQ(intrQ), .vecAddr(vecAddr)
  );

  irq_ctrl ctrl_i (
    .clk(clk), .rst(rst), .boundary(boundary), .haltIn(haltIn),
    .ifFlag(ifFlag), .nmiPend(nmiPend), .intrQ(intrQ),
    .busPhase(busPhase), .busDone(busDone), .strb(strb),
    .ackReq(ackReq), .ackFirst(ackFirst), .lockOut(lockOut), .bheN(bheN),
    .holdBlock(holdBlock), .clearIf(clearIf), .wakeOut(wakeOut),
    .vecValid(vecValid)
  );
endmodule

// File: tb/irq_ack_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_ack_ctrl_tb_top;
  logic clk = 0, rst = 1;
  logic nmiIn = 0, intrIn = 0, boundary = 0, ifFlag = 0, haltIn = 0;
  logic [1:0] busPhase = 0;
  logic busDone = 0;
  logic [7:0] dataIn = 0;
  logic ackReq, ackFirst, lockOut, bheN, holdBlock, clearIf, wakeOut, vecValid;
  logic [9:0] vecAddr;

  int checks = 0, fails = 0;
  logic [7:0] nextType = 0;
  logic [9:0] expQ[$];

  always #4 clk = ~clk;

  irq_ack_ctrl dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: pulse a boundary; push the expected vector when a take is expected.
  task automatic pulseBoundary(input string req, input logic expTake,
                               input logic isNmi, input logic [9:0] expAddr);
    @(negedge clk);
    boundary = 1;
    #1 chk(req, clearIf, expTake);
    if (expTake) expQ.push_back(expAddr);
    @(negedge clk);
    boundary = 0;
    if (expTake && isNmi) #1 chk("R2 no ack cycle", ackReq, 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Bus engine: runs the acknowledge pair and checks lock, byte-high enable, hold.
  initial forever begin
    @(negedge clk);
    if (ackReq) begin
      for (int cyc = 0; cyc < 2; cyc++) begin
        for (int ph = 0; ph < 4; ph++) begin
          busPhase = 2'(ph);
          busDone  = (ph == 3);
          dataIn   = (cyc == 1) ? nextType : 8'h00;
          #1;
          chk("R4 ackFirst", ackFirst, (cyc == 0));
          chk("R4 ackReq", ackReq, 1);
          chk("R5 lock", lockOut, (cyc == 0) ? (ph != 0) : (ph == 0));
          chk("R8 bheN", bheN, !(cyc == 0 && ph == 0));
          chk("R6 holdBlock", holdBlock, 1);
          @(negedge clk);
        end
      end
      busDone = 0; busPhase = 0; dataIn = 0;
      #1 chk("R6 hold released", holdBlock, 0);
    end
  end

  // Monitor: pops expected vectors as the design produces them.
  initial forever begin
    @(negedge clk);
    #2;
    if (vecValid) begin
      if (expQ.size() == 0) chk("R7 unexpected vector", vecAddr, 10'h3ff + 1);
      else chk("R7/R2 vector", vecAddr, expQ.pop_front());
    end
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    nmiIn = 1; // R11: high through reset
    idle(5);
    @(negedge clk); rst = 0;
    #1;
    chk("R1 ackReq", ackReq, 0);  chk("R1 lockOut", lockOut, 0);
    chk("R1 holdBlock", holdBlock, 0); chk("R1 vecValid", vecValid, 0);
    chk("R1 clearIf", clearIf, 0); chk("R1 wakeOut", wakeOut, 0);
    chk("R1 bheN", bheN, 1);
    idle(6);
    pulseBoundary("R11 held nmi ignored", 0, 0, 0);
    nmiIn = 0;
    idle(4);

    // R3: masked by flag, then same-edge request, then proper request
    @(negedge clk); intrIn = 1;
    idle(2);
    pulseBoundary("R3 flag low", 0, 0, 0);
    intrIn = 0; ifFlag = 1;
    idle(2);
    @(negedge clk); intrIn = 1; boundary = 1;
    #1 chk("R3 same-edge request", clearIf, 0);
    @(negedge clk); boundary = 0;
    nextType = 8'h21;
    pulseBoundary("R3 R9 request taken", 1, 0, 10'h084);
    intrIn = 0;
    idle(14);

    // R2: NMI beats qualified request, then request follows
    nmiIn = 1; intrIn = 1;
    idle(5);
    pulseBoundary("R2 R9 nmi first", 1, 1, 10'h008);
    nextType = 8'hFF;
    pulseBoundary("R2 request after nmi", 1, 0, 10'h3FC);
    intrIn = 0;
    idle(14);
    pulseBoundary("R10 held level once", 0, 0, 0);
    nmiIn = 0;
    idle(4);

    // R10: new edge during service gives a second response
    intrIn = 1; nextType = 8'h05;
    pulseBoundary("R10 request", 1, 0, 10'h014);
    intrIn = 0;
    idle(2);
    nmiIn = 1; idle(4); nmiIn = 0;
    idle(10);
    pulseBoundary("R10 second nmi", 1, 1, 10'h008);
    idle(4);

    // R12: halted core woken by request without boundary
    nextType = 8'h40;
    @(negedge clk); haltIn = 1; intrIn = 1;
    @(negedge clk);
    #1 chk("R12 wake", wakeOut, 1);
    chk("R12 R9 clearIf", clearIf, 1);
    expQ.push_back(10'h100);
    @(negedge clk); haltIn = 0; intrIn = 0;
    idle(14);

    chk("R7 all vectors seen", expQ.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule